// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Clock Divider

This block is a register-mapped watchdog. Software programs a control word that holds a run bit, a separate reset-permit bit, an 8-bit prescaler field and a 2-bit divider select. The peripheral clock is first divided by the prescaler field plus one. It is then divided again by 16, 32, 64 or 128. Each resulting tick decrements a 16-bit down-counter.

When a tick arrives while the counter is zero, the counter reloads from a reload register. If both the run bit and the reset-permit bit are set, the block also drives a system reset pulse of a fixed length. Software keeps the system alive by writing the count register, which loads the counter directly. The reload register is locked while the timer runs.

Access is a single-cycle word bus. A write takes effect at the clock edge. Read data is combinational from the word index.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word (index 0) reads 0x0000FF00 (run bit 0 clear, reset-permit bit 1 clear, select bits 3:2 zero, prescaler bits 15:8 all ones). The reload word (index 1) and the count word (index 2) both read 0x00008000, and `sys_rst_o` is low.
- R2: While running, the counter decrements once every (P+1)*2^(4+S) clocks, where P is the prescaler field and S is the select field. The first decrement lands exactly that many clocks after the edge that sets the run bit.
- R3: A write to index 2 loads bits 15:0 into the counter at that edge. This holds whether the timer is running or not, and takes priority over a tick in the same cycle.
- R4: A write to index 1 updates the reload value only while the run bit is clear. While the run bit is set, such a write leaves the value read back unchanged.
- R5: On a tick with the counter at zero, the counter takes the reload value. If the reset-permit bit is clear, `sys_rst_o` stays low.
- R6: On a tick with the counter at zero and both the run and reset-permit bits set, `sys_rst_o` rises at that edge and stays high for RST_CYCLES clocks (default 128).
- R7: While the run bit is clear, the counter holds its value. Setting the run bit restarts both divider stages from zero, so a partial period run earlier is discarded.
- R8: Writing 0 to control, then 1 to count, then 0x3 to control (run and permit, P=0, S=0) raises `sys_rst_o` exactly 32 clocks after the enabling edge, which is two divided ticks.
- R9: The control word reads back its four fields in the positions given in R1, with all other bits zero. The count word reads the live counter. Index 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the addressed word |
| reg_addr_i | input | 2 | Word index: 0 control, 1 reload, 2 count |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The checker watches several properties on every cycle. A count write must appear in the counter one edge later. The reload value must not move under a write made while running. A stopped counter must hold. Every counter change must trace back to a write or a divider tick. A reset pulse must start only while both enable bits were set, and it must last at least RST_CYCLES. Other behaviour can only be shown by the bench scenarios. These include the exact tick period for every prescaler and select value in a small sweep (plus the slowest setting), the restart of the divider on enable, the reload value taken at expiry, and the clock count of the forced-reset sequence.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 2;
  localparam int PRE_W       = 8;
  localparam int SEL_W       = 2;
  localparam int DIV_LOG_MIN = 4;

  localparam int RUN_BIT   = 0;
  localparam int PERMIT_BIT = 1;
  localparam int SEL_LSB   = 2;
  localparam int PRE_LSB   = 8;

  localparam logic [ADDR_W-1:0] IDX_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] IDX_COUNT  = 2'd2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
    logic             permit;
    logic             run;
  } ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[RUN_BIT]                   = c.run;
    w[PERMIT_BIT]                = c.permit;
    w[SEL_LSB +: SEL_W]          = c.sel;
    w[PRE_LSB +: PRE_W]          = c.pre;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.run    = w[RUN_BIT];
    c.permit = w[PERMIT_BIT];
    c.sel    = w[SEL_LSB +: SEL_W];
    c.pre    = w[PRE_LSB +: PRE_W];
    return c;
  endfunction
endpackage

// File: rtl/wd_regs.sv
module wd_regs
  import wd_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_live,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic [REG_W-1:0]  rdata
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             ctrl_we, reload_we;

  always_comb begin
    ctrl_we   = wr && (addr == IDX_CTRL);
    reload_we = wr && (addr == IDX_RELOAD) && !ctrl_q.run;
    ctrl_d    = ctrl_we   ? ctrl_unpack(wdata) : ctrl_q;
    reload_d  = reload_we ? wdata[CNT_W-1:0]   : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.run    <= 1'b0;
      ctrl_q.permit <= 1'b0;
      ctrl_q.sel    <= '0;
      ctrl_q.pre    <= '1;
      reload_q      <= CNT_W'(RST_VAL);
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    unique case (addr)
      IDX_CTRL:   rdata = ctrl_pack(ctrl_q);
      IDX_RELOAD: rdata = REG_W'(reload_q);
      IDX_COUNT:  rdata = REG_W'(cnt_live);
      default:    rdata = '0;
    endcase
  end

  assign ctrl       = ctrl_q;
  assign reload     = reload_q;
  assign cnt_ld     = wr && (addr == IDX_COUNT);
  assign cnt_ld_val = wdata[CNT_W-1:0];
endmodule

// File: rtl/wd_divider.sv
module wd_divider
  import wd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DW   = DIV_LOG_MIN + (1 << SEL_W) - 1;
  localparam int SH_W = $clog2(DIV_LOG_MIN + (1 << SEL_W));

  logic [PRE_W-1:0] pc_q, pc_d;
  logic [DW-1:0]    dc_q, dc_d;
  logic [DW:0]      lim_full;
  logic [DW-1:0]    dlim;
  logic [SH_W-1:0]  shamt;
  logic             pre_hit;

  always_comb begin
    shamt    = SH_W'(DIV_LOG_MIN) + SH_W'(sel);
    lim_full = ((DW+1)'(1) << shamt) - (DW+1)'(1);
    dlim     = lim_full[DW-1:0];
    pre_hit  = run && (pc_q == pre);
    tick     = pre_hit && (dc_q == dlim);

    if (!run)         pc_d = '0;
    else if (pre_hit) pc_d = '0;
    else              pc_d = pc_q + PRE_W'(1);

    if (!run)         dc_d = '0;
    else if (tick)    dc_d = '0;
    else if (pre_hit) dc_d = dc_q + DW'(1);
    else              dc_d = dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      dc_q <= '0;
    end else begin
      pc_q <= pc_d;
      dc_q <= dc_d;
    end
  end
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d  = reload;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wd_pulse.sv
module wd_pulse #(
  parameter int RST_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    if (trig)               left_d = PW'(RST_CYCLES);
    else if (left_q != '0)  left_d = left_q - PW'(1);
    else                    left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wd_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int CNT_RST    = 32768,
  parameter int RST_CYCLES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              sys_rst_o
);
  ctrl_t            ctrl_s;
  logic [CNT_W-1:0] reload_s;
  logic [CNT_W-1:0] cnt_s;
  logic [CNT_W-1:0] ld_val_s;
  logic             ld_s;
  logic             tick_s;
  logic             expire_s;
  logic             run_s;
  logic             permit_s;
  logic             reload_try_s;
  logic             unused_wdata;

  assign run_s        = ctrl_s.run;
  assign permit_s     = ctrl_s.permit;
  assign reload_try_s = reg_wr_i && (reg_addr_i == IDX_RELOAD);
  assign unused_wdata = ^{reg_wdata_i[REG_W-1:PRE_LSB+PRE_W],
                          reg_wdata_i[PRE_LSB-1:SEL_LSB+SEL_W]};

  wd_regs #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_regs (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .wr         (reg_wr_i),
    .addr       (reg_addr_i),
    .wdata      (reg_wdata_i),
    .cnt_live   (cnt_s),
    .ctrl       (ctrl_s),
    .reload     (reload_s),
    .cnt_ld     (ld_s),
    .cnt_ld_val (ld_val_s),
    .rdata      (reg_rdata_o)
  );

  wd_divider u_div (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .run   (run_s),
    .pre   (ctrl_s.pre),
    .sel   (ctrl_s.sel),
    .tick  (tick_s)
  );

  wd_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .tick   (tick_s),
    .ld     (ld_s),
    .ld_val (ld_val_s),
    .reload (reload_s),
    .cnt    (cnt_s),
    .expire (expire_s)
  );

  wd_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .trig  (expire_s && permit_s),
    .pulse (sys_rst_o)
  );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             permit,
  input logic             tick,
  input logic             ld,
  input logic [CNT_W-1:0] ld_val,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             reload_try,
  input logic             rst_o
);
  localparam int RW = $clog2(RST_CYCLES + 2) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_len <= '0;
    else if (!rst_o)              run_len <= '0;
    else if (run_len != '1)       run_len <= run_len + RW'(1);
  end

  a_r3_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));

  a_r4_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_try && run) |=> $stable(reload));

  a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));

  a_r2_change_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(ld || tick));

  a_r5_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && cnt == '0) |=> (cnt == $past(reload)));

  a_r6_rst_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(run && permit));

  a_r6_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (run_len >= RW'(RST_CYCLES)));
endmodule

bind wdog_timer wd_checker #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk        (clk_i),
  .rst_n      (rst_ni),
  .run        (run_s),
  .permit     (permit_s),
  .tick       (tick_s),
  .ld         (ld_s),
  .ld_val     (ld_val_s),
  .cnt        (cnt_s),
  .reload     (reload_s),
  .reload_try (reload_try_s),
  .rst_o      (sys_rst_o)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        sys_rst;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdog_timer dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sys_rst_o   (sys_rst)
  );

  function automatic logic [31:0] cw(input int pre, input int sel, input bit permit, input bit run);
    return (32'(pre) << 8) | (32'(sel) << 2) | (32'(permit) << 1) | 32'(run);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_change(input logic [31:0] old, input int limit, output int n);
    logic [31:0] d;
    n = 0;
    rreg(2'd2, d);
    while (d == old && n < limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      rreg(2'd2, d);
    end
  endtask

  task automatic wait_rst(input int limit, output int n);
    n = 0;
    #1;
    while (!sys_rst && n < limit) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, m;
    rst_n = 1'b0; wr = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rreg(2'd0, d); chk("R1 ctrl reset", d, 32'h0000FF00);
    rreg(2'd1, d); chk("R1 reload reset", d, 32'h00008000);
    rreg(2'd2, d); chk("R1 count reset", d, 32'h00008000);
    chk("R1 sys_rst low", {31'd0, sys_rst}, 32'd0);

    // R9 readback layout
    wreg(2'd0, 32'hFFFF_A5FE);
    rreg(2'd0, d); chk("R9 ctrl fields", d, 32'h0000A50E);
    rreg(2'd3, d); chk("R9 index 3 zero", d, 32'h0);

    // R2 sweep of prescaler and select
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        wreg(2'd0, cw(p, s, 1'b0, 1'b0));
        wreg(2'd2, 32'd5);
        wreg(2'd0, cw(p, s, 1'b0, 1'b1));
        wait_change(32'd5, 2000, n);
        chk($sformatf("R2 period p=%0d s=%0d", p, s), 32'(n), 32'((p + 1) * (16 << s)));
        rreg(2'd2, d); chk("R9 live count", d, 32'd4);
      end
    end
    // R2 slowest setting
    wreg(2'd0, cw(255, 3, 1'b0, 1'b0));
    wreg(2'd2, 32'd2);
    wreg(2'd0, cw(255, 3, 1'b0, 1'b1));
    wait_change(32'd2, 40000, n);
    chk("R2 slowest period", 32'(n), 32'd32768);

    // R3 kick while running (slow divider, no tick interferes)
    wreg(2'd2, 32'h0000_00AA);
    rreg(2'd2, d); chk("R3 kick load", d, 32'hAA);
    wreg(2'd2, 32'hABCD_FFFF);
    rreg(2'd2, d); chk("R3 kick full width", d, 32'hFFFF);

    // R5 reload at expiry, no reset without permit
    wreg(2'd0, cw(0, 0, 1'b0, 1'b0));
    wreg(2'd1, 32'd3);
    wreg(2'd2, 32'd1);
    wreg(2'd0, cw(0, 0, 1'b0, 1'b1));
    wait_change(32'd1, 100, n);
    chk("R5 first tick", 32'(n), 32'd16);
    wait_change(32'd0, 100, n);
    chk("R5 expiry tick", 32'(n), 32'd16);
    rreg(2'd2, d); chk("R5 reloaded", d, 32'd3);
    chk("R5 no reset without permit", {31'd0, sys_rst}, 32'd0);

    // R6 reset pulse with both bits
    wreg(2'd0, cw(0, 0, 1'b0, 1'b0));
    wreg(2'd1, 32'd100);
    wreg(2'd2, 32'd0);
    wreg(2'd0, cw(0, 0, 1'b1, 1'b1));
    wait_rst(200, n);
    chk("R6 reset onset", 32'(n), 32'd16);
    m = 0;
    while (sys_rst && m < 400) begin
      @(posedge clk); @(negedge clk); m++; #1;
    end
    chk("R6 pulse length", 32'(m), 32'd128);

    // R4 reload lockout while running, accepted when stopped
    wreg(2'd1, 32'h1234);
    rreg(2'd1, d); chk("R4 ignored while running", d, 32'd100);
    wreg(2'd0, cw(0, 0, 1'b0, 1'b0));
    wreg(2'd1, 32'h1234);
    rreg(2'd1, d); chk("R4 accepted while stopped", d, 32'h1234);

    // R7 hold while stopped, divider restart on enable
    wreg(2'd2, 32'd9);
    repeat (50) @(negedge clk);
    rreg(2'd2, d); chk("R7 hold while stopped", d, 32'd9);
    wreg(2'd0, cw(0, 0, 1'b0, 1'b1));
    repeat (8) @(negedge clk);
    wreg(2'd0, cw(0, 0, 1'b0, 1'b0));
    rreg(2'd2, d); chk("R7 no tick in partial run", d, 32'd9);
    wreg(2'd0, cw(0, 0, 1'b0, 1'b1));
    wait_change(32'd9, 100, n);
    chk("R7 divider restarted", 32'(n), 32'd16);

    // R8 forced reset sequence
    wreg(2'd0, 32'd0);
    wreg(2'd2, 32'd1);
    wreg(2'd0, 32'd3);
    wait_rst(200, n);
    chk("R8 forced reset clocks", 32'(n), 32'd32);
    wreg(2'd0, 32'd0);
    repeat (140) @(negedge clk);
    #1;
    chk("R8 pulse ended", {31'd0, sys_rst}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule